// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel

This block is a single channel of a counter/timer peripheral. A 16-bit count advances by one on every step. Three sources can supply the step: the system clock, an internal prescaler, or an external single-cycle tick. The channel is programmed through three registers, which hold the count, an operating mode word and a compare target. The count can be made to return to zero after it passes the target, or to run freely and wrap after 0xFFFF. Either event can raise a one-cycle interrupt pulse, and can also set sticky status bits in the mode word that software later reads.

The parameter `CHANNEL` (0, 1 or 2) selects the variant, and the variant fixes which mode bits choose the step source. Channel 0 can step once every five clocks. Channel 1 can step on an external horizontal-sync tick. Channel 2 can step once every eight clocks, and it can also be halted. Each variant raises its interrupt on a different bit of an 8-bit request vector, so an interrupt controller can OR several channels together. Bus decoding, the interrupt controller and the video timing that generates the sync tick all sit outside this block.

Top module: `timer_channel`

## Requirements
- R1: Register select `addr` is 0 = count, 1 = mode, 2 = target, and 3 is unused. `rdata` shows the selected register combinationally, with the 16-bit mode word zero-extended. A count write loads the low 16 bits of `wdata`.
- R2: Each step adds one to the count. A step taken while the count is 0xFFFF returns it to 0, and that step is an overflow event.
- R3: A step taken while the count equals the target is a target event. With mode bit 3 set, the count goes to 0 on that step. With bit 3 clear, the count keeps incrementing past the target.
- R4: Mode bit 4 enables the interrupt on target events, and mode bit 5 enables it on overflow events. An enabled event drives bit 4+CHANNEL of `irq_vec` high for exactly the one cycle after the stepping edge (0x10, 0x20, 0x40). All other bits of `irq_vec` stay low.
- R5: When mode bit 6 is clear (one-shot), only the first enabled event after a mode write raises a pulse. When bit 6 is set (repeat), every enabled event raises a pulse.
- R6: A target event sets mode bit 11 and an overflow event sets mode bit 12. Either event also sets mode bit 10. A mode read (`rd_en` with `addr` 1) returns the word and then clears bits 11 and 12 only, leaving bit 10. If an event and a read occur in the same cycle, the event's setting wins.
- R7: A mode write stores the low 16 bits of `wdata`, sets the count to 0, re-arms the one-shot interrupt and restarts the internal prescaler.
- R8: A target write leaves the count unchanged. Any register write suppresses the count step in the cycle it is applied.
- R9: Channel 0 with mode bit 8 set steps once every 5 clocks, and the first step lands on the 5th edge after the mode write.
- R10: Channel 1 with mode bit 8 set steps only in cycles where `hsync_tick` is high.
- R11: Channel 2 with mode bit 9 set steps once every 8 clocks. With mode bit 0 set, channel 2 does not step at all.
- R12: While `rst_n` is low, the count, mode and target registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on a mode read) |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data; the low 16 bits are used |
| rdata | output | 16 | Selected register value |
| hsync_tick | input | 1 | Single-cycle external tick (used by channel 1) |
| irq_vec | output | 8 | Interrupt request vector, one bit per channel variant |

## Verification
The assertions assume that `hsync_tick` is a clean single-cycle pulse and that software never writes the mode register and reads it in the same cycle. Under those assumptions, register writes are the only thing that can interrupt stepping. The stimulus issues each access for exactly one cycle and drives it away from the clock edge. It raises the sync tick only as isolated one-cycle pulses. Before any count-dependent check, it writes the target first and the mode second, so that the count restarts from a known zero.

// File: rtl/timer_ch_pkg.sv
`timescale 1ns/1ps
package timer_ch_pkg;
   // mode word bit positions
   localparam int MB_HALT    = 0;
   localparam int MB_RST_TGT = 3;
   localparam int MB_IRQ_TGT = 4;
   localparam int MB_IRQ_OVF = 5;
   localparam int MB_REPEAT  = 6;
   localparam int MB_SRC_A   = 8;
   localparam int MB_SRC_B   = 9;
   localparam int MB_EVT     = 10;
   localparam int MB_HIT_TGT = 11;
   localparam int MB_HIT_OVF = 12;
   localparam int MODE_W     = 16;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_MODE   = 2'd1,
      REG_TARGET = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/timer_tick_sel.sv
`timescale 1ns/1ps
module timer_tick_sel #(
   parameter int CHANNEL  = 0,
   parameter int PIX_DIV  = 5,
   parameter int SLOW_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic src_a,
   input  logic src_b,
   input  logic halt,
   input  logic hsync_tick,
   output logic step
);
   if (CHANNEL == 1) begin : g_hsync
      logic unused_in;
      assign unused_in = ^{clk, rst_n, restart, src_b, halt};
      assign step = src_a ? hsync_tick : 1'b1;
   end else begin : g_div
      localparam int DIV = (CHANNEL == 0) ? PIX_DIV : SLOW_DIV;
      localparam int PW  = (DIV > 2) ? $clog2(DIV) : 1;
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      if (DIV < 2) begin : g_bad_div
         $error("timer_tick_sel: divider must be at least 2");
      end

      logic [PW-1:0] pre_q;
      logic          pre_hit;
      assign pre_hit = (pre_q == LAST);

      always_ff @(posedge clk) begin
         if (!rst_n || restart) pre_q <= '0;
         else if (pre_hit)      pre_q <= '0;
         else                   pre_q <= pre_q + PW'(1);
      end

      if (CHANNEL == 0) begin : g_pix
         logic unused_in;
         assign unused_in = ^{src_b, halt, hsync_tick};
         assign step = src_a ? pre_hit : 1'b1;
      end else begin : g_slow
         logic unused_in;
         assign unused_in = ^{src_a, hsync_tick};
         assign step = halt ? 1'b0 : (src_b ? pre_hit : 1'b1);

         // R11: a halted channel never advances its prescaled step
         p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (halt && src_b) |-> !step);
      end
   end
endmodule

// File: rtl/timer_count_core.sv
`timescale 1ns/1ps
module timer_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             hold,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             rst_at_tgt,
   input  logic [CNT_W-1:0] target,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit_tgt,
   output logic             hit_ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic live;
   assign live    = step && !hold;
   assign hit_tgt = live && (cnt_q == target);
   assign hit_ovf = live && (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (load)                  cnt_q <= load_val;
      else if (live) begin
         if (hit_ovf)                 cnt_q <= '0;
         else if (hit_tgt && rst_at_tgt) cnt_q <= '0;
         else                         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hold && cnt_q == CNT_MAX) |=> (cnt_q == '0));

   p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hold && cnt_q != CNT_MAX && cnt_q != target)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   p_tgt_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hold && rst_at_tgt && cnt_q == target) |=> (cnt_q == '0));

   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr && !load) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/timer_irq_gen.sv
`timescale 1ns/1ps
module timer_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_tgt,
   input  logic hit_ovf,
   input  logic en_tgt,
   input  logic en_ovf,
   input  logic rpt_en,
   input  logic rearm,
   output logic irq_q
);
   logic fired_q;
   logic fire;

   assign fire = ((hit_tgt && en_tgt) || (hit_ovf && en_ovf)) && (rpt_en || !fired_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= fire;
         if (rearm)     fired_q <= 1'b0;
         else if (fire) fired_q <= 1'b1;
      end
   end

   p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !rpt_en && !rearm) |=> !irq_q);

   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_tgt && !hit_ovf) |=> !irq_q);
endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
   import timer_ch_pkg::*;
#(
   parameter int CHANNEL  = 0,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 32,
   parameter int PIX_DIV  = 5,
   parameter int SLOW_DIV = 8,
   parameter int IRQ_W    = 8,
   parameter int IRQ_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  rdata,
   input  logic              hsync_tick,
   output logic [IRQ_W-1:0]  irq_vec
);
   localparam int IRQ_POS = IRQ_BASE + CHANNEL;

   if (CHANNEL < 0 || CHANNEL > 2) begin : g_bad_channel
      $error("timer_channel: CHANNEL must be 0, 1 or 2");
   end
   if (CNT_W < MODE_W) begin : g_bad_cnt
      $error("timer_channel: CNT_W must hold the mode word");
   end
   if (DATA_W <= CNT_W) begin : g_bad_data
      $error("timer_channel: DATA_W must exceed CNT_W");
   end
   if (IRQ_POS >= IRQ_W) begin : g_bad_irq
      $error("timer_channel: interrupt bit outside vector");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   logic wr_cnt, wr_mode, wr_tgt, any_wr, rd_mode;
   assign wr_cnt  = wr_en && (sel == REG_COUNT);
   assign wr_mode = wr_en && (sel == REG_MODE);
   assign wr_tgt  = wr_en && (sel == REG_TARGET);
   assign any_wr  = wr_cnt || wr_mode || wr_tgt;
   assign rd_mode = rd_en && (sel == REG_MODE);

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  target_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              step, hit_tgt, hit_ovf, irq_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n)      target_q <= '0;
      else if (wr_tgt) target_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_mode) begin
         mode_q <= wdata[MODE_W-1:0];
      end else begin
         if (rd_mode) begin
            mode_q[MB_HIT_TGT] <= 1'b0;
            mode_q[MB_HIT_OVF] <= 1'b0;
         end
         if (hit_tgt)            mode_q[MB_HIT_TGT] <= 1'b1;
         if (hit_ovf)            mode_q[MB_HIT_OVF] <= 1'b1;
         if (hit_tgt || hit_ovf) mode_q[MB_EVT]     <= 1'b1;
      end
   end

   timer_tick_sel #(
      .CHANNEL  (CHANNEL),
      .PIX_DIV  (PIX_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) tick_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (wr_mode),
      .src_a      (mode_q[MB_SRC_A]),
      .src_b      (mode_q[MB_SRC_B]),
      .halt       (mode_q[MB_HALT]),
      .hsync_tick (hsync_tick),
      .step       (step)
   );

   timer_count_core #(
      .CNT_W (CNT_W)
   ) core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .hold       (any_wr),
      .clr        (wr_mode),
      .load       (wr_cnt),
      .load_val   (wdata[CNT_W-1:0]),
      .rst_at_tgt (mode_q[MB_RST_TGT]),
      .target     (target_q),
      .cnt_q      (cnt_q),
      .hit_tgt    (hit_tgt),
      .hit_ovf    (hit_ovf)
   );

   timer_irq_gen irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_tgt (hit_tgt),
      .hit_ovf (hit_ovf),
      .en_tgt  (mode_q[MB_IRQ_TGT]),
      .en_ovf  (mode_q[MB_IRQ_OVF]),
      .rpt_en  (mode_q[MB_REPEAT]),
      .rearm   (wr_mode),
      .irq_q   (irq_pulse)
   );

   always_comb begin
      unique case (sel)
         REG_COUNT:  rdata = cnt_q;
         REG_MODE:   rdata = CNT_W'(mode_q);
         REG_TARGET: rdata = target_q;
         default:    rdata = '0;
      endcase
   end

   always_comb begin
      irq_vec          = '0;
      irq_vec[IRQ_POS] = irq_pulse;
   end

   p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && !wr_mode && !hit_tgt && !hit_ovf)
      |=> (!mode_q[MB_HIT_TGT] && !mode_q[MB_HIT_OVF]));

   p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_tgt || hit_ovf) |=> mode_q[MB_EVT]);

   p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_vec));
endmodule

// File: tb/timer_channel_tb_top.sv
`timescale 1ns/1ps
module timer_channel_tb_top;
   logic        clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rst_n;
   logic [2:0]  wr_en, rd_en;
   logic [1:0]  addr;
   logic [31:0] wdata;
   logic        hsync;
   logic [15:0] rd0, rd1, rd2;
   logic [7:0]  iv0, iv1, iv2;

   int n_cmp = 0;
   int n_bad = 0;

   timer_channel #(.CHANNEL(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .rd_en(rd_en[0]), .addr(addr),
      .wdata(wdata), .rdata(rd0), .hsync_tick(hsync), .irq_vec(iv0));
   timer_channel #(.CHANNEL(1)) dut1_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .rd_en(rd_en[1]), .addr(addr),
      .wdata(wdata), .rdata(rd1), .hsync_tick(hsync), .irq_vec(iv1));
   timer_channel #(.CHANNEL(2)) dut2_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[2]), .rd_en(rd_en[2]), .addr(addr),
      .wdata(wdata), .rdata(rd2), .hsync_tick(hsync), .irq_vec(iv2));

   typedef struct packed {
      logic [15:0] mode;
      logic [15:0] tgt;
      logic        pre_en;
      logic [15:0] pre;
      logic [7:0]  wait_n;
      logic [15:0] exp_cnt;
      logic [15:0] exp_mode;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{16'h0000, 16'h0010, 1'b0, 16'h0000, 8'd5,  16'd5, 16'h0000},
      '{16'h0008, 16'h0003, 1'b0, 16'h0000, 8'd9,  16'd1, 16'h0C08},
      '{16'h0000, 16'h0003, 1'b0, 16'h0000, 8'd6,  16'd6, 16'h0C00},
      '{16'h0000, 16'h0100, 1'b1, 16'hFFFD, 8'd4,  16'd1, 16'h1400},
      '{16'h0008, 16'hFFFF, 1'b1, 16'hFFFE, 8'd3,  16'd1, 16'h1C08},
      '{16'h0100, 16'h0100, 1'b0, 16'h0000, 8'd12, 16'd2, 16'h0100},
      '{16'h0000, 16'h0000, 1'b0, 16'h0000, 8'd3,  16'd3, 16'h0C00}
   };

   function automatic logic [15:0] rd_of(input int ch);
      case (ch)
         0:       return rd0;
         1:       return rd1;
         default: return rd2;
      endcase
   endfunction

   function automatic logic [7:0] irq_of(input int ch);
      case (ch)
         0:       return iv0;
         1:       return iv1;
         default: return iv2;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // all tasks start just after a falling edge
   task automatic wr(input int ch, input logic [1:0] a, input logic [31:0] v);
      wr_en[ch] = 1'b1; addr = a; wdata = v;
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic peek(input int ch, input logic [1:0] a, output logic [15:0] v);
      addr = a;
      #1 v = rd_of(ch);
   endtask

   task automatic rd_mode(input int ch, output logic [15:0] v);
      addr = 2'd1; rd_en[ch] = 1'b1;
      #1 v = rd_of(ch);
      @(negedge clk);
      rd_en = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_irq(input int ch, input int cycles, input logic [7:0] line,
                            output int pulses, output int wrong);
      pulses = 0; wrong = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         #1;
         if (irq_of(ch) == line) pulses++;
         else if (irq_of(ch) != 8'h00) wrong++;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int p, w;
      rst_n = 1'b0; wr_en = '0; rd_en = '0; addr = '0; wdata = '0; hsync = 1'b0;
      idle(3);
      // R12 reset state
      peek(0, 2'd0, v); chk("R12 count", v, 0);
      peek(0, 2'd1, v); chk("R12 mode", v, 0);
      peek(0, 2'd2, v); chk("R12 target", v, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk (R2 R3 R6 R9)
      for (int k = 0; k < NVEC; k++) begin
         wr(0, 2'd2, {16'h0, VECS[k].tgt});
         wr(0, 2'd1, {16'h0, VECS[k].mode});
         if (VECS[k].pre_en) wr(0, 2'd0, {16'h0, VECS[k].pre});
         idle(int'(VECS[k].wait_n));
         peek(0, 2'd0, v);
         chk($sformatf("R2 R3 table %0d count", k), v, VECS[k].exp_cnt);
         rd_mode(0, v);
         chk($sformatf("R6 table %0d mode", k), v, VECS[k].exp_mode);
      end

      // R1 count write uses the low 16 bits
      wr(0, 2'd1, 32'h0);
      wr(0, 2'd0, 32'h0001_2345);
      peek(0, 2'd0, v); chk("R1 count load", v, 16'h2345);

      // R7 mode write clears the count
      idle(3);
      wr(0, 2'd1, 32'h0);
      peek(0, 2'd0, v); chk("R7 mode write clears count", v, 0);

      // R8 target write keeps the count and suppresses the step
      idle(4);
      peek(0, 2'd0, v); chk("R8 before target write", v, 4);
      wr(0, 2'd2, 32'h7000);
      peek(0, 2'd0, v); chk("R8 after target write", v, 4);
      idle(2);
      peek(0, 2'd0, v); chk("R8 resumes", v, 6);

      // R6 read clears bits 11/12 but keeps bit 10
      wr(0, 2'd2, 32'd3);
      wr(0, 2'd1, 32'h0);
      idle(6);
      rd_mode(0, v); chk("R6 first read", v, 16'h0C00);
      peek(0, 2'd1, v); chk("R6 after read", v, 16'h0400);

      // R5 one-shot versus repeat, R4 line and enables
      wr(0, 2'd2, 32'd2);
      wr(0, 2'd1, 32'h0018);
      count_irq(0, 20, 8'h10, p, w);
      chk("R5 one-shot pulses", p, 1);
      chk("R4 wrong line", w, 0);
      wr(0, 2'd1, 32'h0058);
      count_irq(0, 20, 8'h10, p, w);
      chk("R5 repeat pulses", p, 6);
      wr(0, 2'd1, 32'h0008);
      count_irq(0, 20, 8'h10, p, w);
      chk("R4 disabled pulses", p + w, 0);
      wr(0, 2'd2, 32'h0100);
      wr(0, 2'd1, 32'h0020);
      wr(0, 2'd0, 32'hFFFE);
      count_irq(0, 5, 8'h10, p, w);
      chk("R4 overflow pulses", p, 1);

      // R9 pixel tick boundary
      wr(0, 2'd1, 32'h0100);
      idle(4);
      peek(0, 2'd0, v); chk("R9 before 5th edge", v, 0);
      idle(1);
      peek(0, 2'd0, v); chk("R9 at 5th edge", v, 1);

      // R10 channel 1 sync tick
      wr(1, 2'd1, 32'h0100);
      idle(5);
      peek(1, 2'd0, v); chk("R10 no tick", v, 0);
      for (int j = 0; j < 3; j++) begin
         hsync = 1'b1;
         @(negedge clk);
         hsync = 1'b0;
         idle(2);
      end
      peek(1, 2'd0, v); chk("R10 three ticks", v, 3);
      wr(1, 2'd2, 32'd0);
      wr(1, 2'd1, 32'h0018);
      @(negedge clk); #1;
      chk("R4 channel 1 line", irq_of(1), 8'h20);

      // R11 channel 2 divide and halt
      wr(2, 2'd1, 32'h0200);
      idle(24);
      peek(2, 2'd0, v); chk("R11 divide by 8", v, 3);
      wr(2, 2'd1, 32'h0201);
      idle(10);
      peek(2, 2'd0, v); chk("R11 halt prescaled", v, 0);
      wr(2, 2'd1, 32'h0001);
      idle(5);
      peek(2, 2'd0, v); chk("R11 halt sysclk", v, 0);
      wr(2, 2'd2, 32'd0);
      wr(2, 2'd1, 32'h0018);
      @(negedge clk); #1;
      chk("R4 channel 2 line", irq_of(2), 8'h40);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule